// File: doc/BRIEF.md
# Read-Burst Interruption Rule Monitor

This block watches the command stream that a DDR DRAM controller sends, one command per clock, and checks the rules for cutting a read burst short. It recognises five command kinds: idle, read, read with auto-precharge, write and burst stop. It keeps track of three things: whether a read burst is still driving data, whether that burst was ended by a burst stop, and how many clocks have passed since the last burst stop.

Each rule has its own violation output. The output pulses in the same clock as the offending write. A sticky error vector remembers every rule that has fired until software-side logic clears it with a synchronous clear input.

The CAS latency and the burst length are read from input pins while reset is held. These pins stand in for a mode register, and later changes on them are ignored. The block checks timing only. It does not track bank state and has no data path.

Top module: `rdwr_legality_mon`

## Requirements
- R1: The values on `cl_int`, `cl_half` and `bl_sel` are captured on every clock while `rst_n` is low. After reset is released, changing them has no effect on any rule.
- R2: Command encoding on `cmd` is 0 idle, 1 read, 2 read with auto-precharge, 3 write, 4 burst stop, and 5 to 7 act as idle. A write (3) that arrives while a plain read burst is active, with no burst stop since that read, raises `viol_nostop` in that same clock. A write outside any burst raises nothing.
- R3: The rounded latency CLR is `cl_int + cl_half`. The half-burst count is 1, 2 or 4 for `bl_sel` 0, 1 or 2, and 4 for `bl_sel` 3. A burst from a read issued in clock t is active in clocks t+1 through t+CLR+half-burst, inclusive.
- R4: A write that comes fewer than CLR clocks after a burst stop raises `viol_gap` in that clock. With latency 2, a gap of 1 is flagged and a gap of 2 is legal.
- R5: With latency 2.5 (`cl_int`=2, `cl_half`=1) the minimum gap is 3. A gap of 2 is flagged and a gap of 3 is legal.
- R6: A write during the active burst of a read with auto-precharge raises `viol_ap` whether or not a burst stop came first. It never also raises `viol_nostop`.
- R7: A read or auto-precharge read may follow another read after any spacing of one clock or more. It raises no violation, and it restarts the active window and clears the burst-stop mark.
- R8: `sticky_err` bit 0 is set by `viol_nostop`, bit 1 by `viol_gap` and bit 2 by `viol_ap`. Each bit is set one clock after its pulse and holds until a clock with `clr_sticky` high clears all bits. A clear in the same clock as a pulse wins.
- R9: While `rst_n` is low, all violation outputs are 0 even if a write is presented. `sticky_err` reads 0 from the first clock of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are sampled while low |
| cmd | input | 3 | Command issued in this clock |
| cl_int | input | CL_W | Integer part of CAS latency |
| cl_half | input | 1 | Adds a half clock to the CAS latency |
| bl_sel | input | BLS_W | Burst length select (2, 4, 8, 8) |
| clr_sticky | input | 1 | Synchronous clear of the sticky error vector |
| viol_nostop | output | 1 | Write cut into a plain read burst without a burst stop |
| viol_gap | output | 1 | Write came too soon after a burst stop |
| viol_ap | output | 1 | Write cut into an auto-precharge read burst |
| sticky_err | output | 3 | Accumulated violations {ap, gap, nostop} |

## Verification
The three violation outputs depend combinationally on the current command, so each one is due in the clock the write is presented. The bench drives commands just after a rising edge and samples the pulses at the following falling edge. A sticky bit is due one edge later, so the bench checks it at the falling edge of the next clock. A reference model with integer clock stamps predicts all four outputs for every cycle. The directed checks sit exactly at the window and gap boundaries, one clock inside and one clock outside.

// File: rtl/ddr_rdwr_pkg.sv
package ddr_rdwr_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE = 3'd0,
      CMD_RD   = 3'd1,
      CMD_RDAP = 3'd2,
      CMD_WR   = 3'd3,
      CMD_BST  = 3'd4
   } cmd_e;

   localparam int RULE_NOSTOP = 0;
   localparam int RULE_GAP    = 1;
   localparam int RULE_AP     = 2;
   localparam int NUM_RULES   = 3;

   // largest half-burst select that maps to a distinct length
   localparam int BL_SEL_TOP  = 2;

endpackage

// File: rtl/rdwr_mode_latch.sv
module rdwr_mode_latch #(
   parameter int CL_W  = 2,
   parameter int BLS_W = 2,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CL_W-1:0]  cl_int_in,
   input  logic             cl_half_in,
   input  logic [BLS_W-1:0] bl_sel_in,
   output logic [CNT_W-1:0] lat_rnd,
   output logic [CNT_W-1:0] win_len
);
   import ddr_rdwr_pkg::*;

   logic [CL_W-1:0]  cl_q;
   logic             half_q;
   logic [BLS_W-1:0] bls_q;
   logic [CNT_W-1:0] half_burst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl_q   <= cl_int_in;
         half_q <= cl_half_in;
         bls_q  <= bl_sel_in;
      end
   end

   // rounding up the half clock is simply adding it as a whole clock
   assign lat_rnd = CNT_W'(cl_q) + CNT_W'(half_q);

   always_comb begin
      if (int'(bls_q) >= BL_SEL_TOP)
         half_burst = CNT_W'(1) << BL_SEL_TOP;
      else
         half_burst = CNT_W'(1) << bls_q;
   end

   assign win_len = lat_rnd + half_burst;

endmodule

// File: rtl/rdwr_read_tracker.sv
module rdwr_read_tracker #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_start,
   input  logic             rd_autopre,
   input  logic             bst_seen,
   input  logic [CNT_W-1:0] win_len,
   output logic             burst_live,
   output logic             burst_ap,
   output logic             burst_cut
);
   logic [CNT_W-1:0] beats_left;
   logic             ap_q;
   logic             cut_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beats_left <= '0;
         ap_q       <= 1'b0;
         cut_q      <= 1'b0;
      end else if (rd_start) begin
         beats_left <= win_len;
         ap_q       <= rd_autopre;
         cut_q      <= 1'b0;
      end else begin
         if (beats_left != '0)
            beats_left <= beats_left - CNT_W'(1);
         if (bst_seen)
            cut_q <= 1'b1;
      end
   end

   assign burst_live = (beats_left != '0);
   assign burst_ap   = ap_q;
   assign burst_cut  = cut_q;

endmodule

// File: rtl/rdwr_stop_timer.sv
module rdwr_stop_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bst_seen,
   input  logic [CNT_W-1:0] lat_rnd,
   output logic             too_soon
);
   localparam logic [CNT_W-1:0] AGE_SAT = {CNT_W{1'b1}};

   logic [CNT_W-1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n)
         age <= AGE_SAT;
      else if (bst_seen)
         age <= CNT_W'(1);
      else if (age != AGE_SAT)
         age <= age + CNT_W'(1);
   end

   assign too_soon = (age < lat_rnd);

endmodule

// File: rtl/rdwr_rule_eval.sv
module rdwr_rule_eval #(
   parameter int NR = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          is_wr,
   input  logic          burst_live,
   input  logic          burst_ap,
   input  logic          burst_cut,
   input  logic          too_soon,
   output logic [NR-1:0] pulse,
   output logic [NR-1:0] sticky
);
   import ddr_rdwr_pkg::*;

   logic [NR-1:0] raw;

   always_comb begin
      raw = '0;
      raw[RULE_NOSTOP] = is_wr && burst_live && !burst_ap && !burst_cut;
      raw[RULE_GAP]    = is_wr && too_soon;
      raw[RULE_AP]     = is_wr && burst_live && burst_ap;
   end

   assign pulse = raw & {NR{rst_n}};

   for (genvar gi = 0; gi < NR; gi++) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            sticky[gi] <= 1'b0;
         else if (pulse[gi])
            sticky[gi] <= 1'b1;
      end
   end

endmodule

// File: rtl/rdwr_legality_mon.sv
module rdwr_legality_mon #(
   parameter int CL_W  = 2,
   parameter int BLS_W = 2,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd,
   input  logic [CL_W-1:0]  cl_int,
   input  logic             cl_half,
   input  logic [BLS_W-1:0] bl_sel,
   input  logic             clr_sticky,
   output logic             viol_nostop,
   output logic             viol_gap,
   output logic             viol_ap,
   output logic [2:0]       sticky_err
);
   import ddr_rdwr_pkg::*;

   localparam int WIN_TOP = (1 << CL_W) + (1 << BL_SEL_TOP);
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   if (WIN_TOP > CNT_TOP) begin : g_bad_cnt
      $error("CNT_W too narrow for the largest burst window");
   end
   if (BLS_W < 2) begin : g_bad_bls
      $error("BLS_W must be at least 2");
   end

   cmd_e             cmd_k;
   logic             is_rd, is_rdap, is_wr, is_bst;
   logic [CNT_W-1:0] lat_rnd, win_len;
   logic             burst_live, burst_ap, burst_cut, too_soon;
   logic [NUM_RULES-1:0] pulse, sticky;

   assign cmd_k   = cmd_e'(cmd);
   assign is_rd   = (cmd_k == CMD_RD);
   assign is_rdap = (cmd_k == CMD_RDAP);
   assign is_wr   = (cmd_k == CMD_WR);
   assign is_bst  = (cmd_k == CMD_BST);

   rdwr_mode_latch #(.CL_W(CL_W), .BLS_W(BLS_W), .CNT_W(CNT_W)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .cl_int_in  (cl_int),
      .cl_half_in (cl_half),
      .bl_sel_in  (bl_sel),
      .lat_rnd    (lat_rnd),
      .win_len    (win_len)
   );

   rdwr_read_tracker #(.CNT_W(CNT_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_start   (is_rd || is_rdap),
      .rd_autopre (is_rdap),
      .bst_seen   (is_bst),
      .win_len    (win_len),
      .burst_live (burst_live),
      .burst_ap   (burst_ap),
      .burst_cut  (burst_cut)
   );

   rdwr_stop_timer #(.CNT_W(CNT_W)) u_stop (
      .clk      (clk),
      .rst_n    (rst_n),
      .bst_seen (is_bst),
      .lat_rnd  (lat_rnd),
      .too_soon (too_soon)
   );

   rdwr_rule_eval #(.NR(NUM_RULES)) u_rules (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_sticky),
      .is_wr      (is_wr),
      .burst_live (burst_live),
      .burst_ap   (burst_ap),
      .burst_cut  (burst_cut),
      .too_soon   (too_soon),
      .pulse      (pulse),
      .sticky     (sticky)
   );

   assign viol_nostop = pulse[RULE_NOSTOP];
   assign viol_gap    = pulse[RULE_GAP];
   assign viol_ap     = pulse[RULE_AP];
   assign sticky_err  = sticky;

endmodule

// File: rtl/rdwr_legality_chk.sv
module rdwr_legality_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] cmd,
   input logic       clr_sticky,
   input logic       viol_nostop,
   input logic       viol_gap,
   input logic       viol_ap,
   input logic [2:0] sticky_err
);
   logic [2:0] pulses;
   assign pulses = {viol_ap, viol_gap, viol_nostop};

   // R2: every violation belongs to a write command
   a_r2_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pulses != 3'b000) |-> (cmd == 3'd3));

   // R6: auto-precharge case never doubles as missing-stop case
   a_r6_ap_not_nostop: assert property (@(posedge clk) disable iff (!rst_n)
      !(viol_ap && viol_nostop));

   // R7: reads are never flagged
   a_r7_reads_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd1 || cmd == 3'd2) |-> (pulses == 3'b000));

   // R8: a pulse without clear lands in the sticky vector
   a_r8_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_sticky && pulses != 3'b000) |=>
         ((sticky_err & $past(pulses)) == $past(pulses)));

   // R8: set bits hold while no clear
   a_r8_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_sticky |=> ((sticky_err & $past(sticky_err)) == $past(sticky_err)));

   // R8: clear empties the vector
   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sticky |=> (sticky_err == 3'b000));

   // R9: reset empties the vector
   a_r9_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (sticky_err == 3'b000));

   // R9: no pulses during reset
   a_r9_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> (pulses == 3'b000));

endmodule

bind rdwr_legality_mon rdwr_legality_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd         (cmd),
   .clr_sticky  (clr_sticky),
   .viol_nostop (viol_nostop),
   .viol_gap    (viol_gap),
   .viol_ap     (viol_ap),
   .sticky_err  (sticky_err)
);

// File: tb/rdwr_legality_mon_bench.sv
`timescale 1ns/1ps
module rdwr_legality_mon_bench;
   localparam logic [2:0] C_NOP = 3'd0, C_RD = 3'd1, C_RDAP = 3'd2,
                          C_WR = 3'd3, C_BST = 3'd4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = C_NOP;
   logic [1:0] cl_int = 2'd2;
   logic       cl_half = 1'b0;
   logic [1:0] bl_sel = 2'd1;
   logic       clr_sticky = 1'b0;
   logic       viol_nostop, viol_gap, viol_ap;
   logic [2:0] sticky_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   rdwr_legality_mon u_rdwr_legality_mon (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .cl_int(cl_int), .cl_half(cl_half),
      .bl_sel(bl_sel), .clr_sticky(clr_sticky), .viol_nostop(viol_nostop),
      .viol_gap(viol_gap), .viol_ap(viol_ap), .sticky_err(sticky_err)
   );

   // ---------------- reference model ----------------
   int m_clu = 2, m_win = 4, m_cyc = 0;
   int m_rd_cyc = -1, m_stop_cyc = -1;
   bit m_rd_ap = 0;
   logic [2:0] m_sticky = 3'b000;

   function automatic logic [2:0] model_pulses(input logic [2:0] c);
      logic [2:0] r = 3'b000;
      bit live, cut;
      if (c != C_WR) return r;
      live = (m_rd_cyc >= 0) && ((m_cyc - m_rd_cyc) <= m_win);
      cut  = (m_stop_cyc > m_rd_cyc);
      r[2] = live && m_rd_ap;
      r[0] = live && !m_rd_ap && !cut;
      r[1] = (m_stop_cyc >= 0) && ((m_cyc - m_stop_cyc) < m_clu);
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         int hb;
         hb = (bl_sel >= 2) ? 4 : (1 << bl_sel);
         m_clu = int'(cl_int) + int'(cl_half);
         m_win = m_clu + hb;
         m_cyc = 0; m_rd_cyc = -1; m_stop_cyc = -1; m_rd_ap = 0;
         m_sticky = 3'b000;
      end else begin
         logic [2:0] p;
         p = model_pulses(cmd);
         if (clr_sticky) m_sticky = 3'b000;
         else            m_sticky = m_sticky | p;
         if (cmd == C_RD || cmd == C_RDAP) begin
            m_rd_cyc = m_cyc; m_rd_ap = (cmd == C_RDAP);
         end else if (cmd == C_BST) begin
            m_stop_cyc = m_cyc;
         end
         m_cyc++;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic [2:0] ep;
         ep = rst_n ? model_pulses(cmd) : 3'b000;
         checks++;
         if ({viol_ap, viol_gap, viol_nostop} !== ep) begin
            fails++;
            $display("FAIL R2,R4,R6 model pulses: actual %b expected %b at %0t",
                     {viol_ap, viol_gap, viol_nostop}, ep, $time);
         end
         checks++;
         if (sticky_err !== m_sticky) begin
            fails++;
            $display("FAIL R8 model sticky: actual %b expected %b at %0t",
                     sticky_err, m_sticky, $time);
         end
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic stepc(input logic [2:0] c, input logic clr);
      @(posedge clk); #1; cmd = c; clr_sticky = clr;
   endtask

   task automatic step(input logic [2:0] c);
      stepc(c, 1'b0);
   endtask

   task automatic pad(input int n);
      for (int i = 0; i < n; i++) step(C_NOP);
   endtask

   function automatic logic [2:0] pv();
      return {viol_ap, viol_gap, viol_nostop};
   endfunction

   task automatic do_reset(input logic [1:0] ci, input logic ch, input logic [1:0] bs);
      @(posedge clk); #1;
      rst_n = 1'b0; cl_int = ci; cl_half = ch; bl_sel = bs;
      cmd = C_WR; clr_sticky = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R9 pulses in reset", pv(), 3'b000);
      chk("R9 sticky in reset", sticky_err, 3'b000);
      @(posedge clk); #1;
      rst_n = 1'b1; cmd = C_NOP;
      // scramble mode pins: must be ignored (R1)
      cl_int = 2'd1; cl_half = 1'b0; bl_sel = 2'd0;
   endtask

   initial begin
      do_reset(2'd2, 1'b0, 2'd1);   // CL2, BL4: CLR 2, window 4
      pad(2);

      // R2 write inside a plain burst, no stop
      step(C_RD); step(C_NOP); step(C_WR);
      @(negedge clk); chk("R2 write cuts burst", pv(), 3'b001);
      step(C_NOP); @(negedge clk); chk("R8 sticky set", sticky_err, 3'b001);
      pad(8);
      step(C_WR); @(negedge clk); chk("R2 write outside burst", pv(), 3'b000);
      @(negedge clk); chk("R8 sticky holds", sticky_err, 3'b001);

      // R3 window edge: k=4 active, k=5 over (also R1: scrambled window would be 2)
      pad(6);
      step(C_RD); pad(3); step(C_WR);
      @(negedge clk); chk("R3 last beat", pv(), 3'b001);
      pad(8);
      step(C_RD); pad(4); step(C_WR);
      @(negedge clk); chk("R3 after window", pv(), 3'b000);

      // R4 stop gap with CLR 2
      pad(8);
      step(C_RD); step(C_BST); step(C_NOP); step(C_WR);
      @(negedge clk); chk("R4 gap 2 legal", pv(), 3'b000);
      pad(8);
      step(C_RD); step(C_NOP); step(C_BST); step(C_WR);
      @(negedge clk); chk("R4 gap 1 flagged", pv(), 3'b010);
      step(C_NOP); @(negedge clk); chk("R8 sticky two bits", sticky_err, 3'b011);

      // R8 clear, and clear beats simultaneous pulse
      stepc(C_NOP, 1'b1); step(C_NOP);
      @(negedge clk); chk("R8 cleared", sticky_err, 3'b000);
      pad(6);
      step(C_RD); step(C_NOP); stepc(C_WR, 1'b1);
      @(negedge clk); chk("R2 pulse with clear", pv(), 3'b001);
      step(C_NOP); @(negedge clk); chk("R8 clear wins", sticky_err, 3'b000);

      // R6 auto-precharge read
      pad(8);
      step(C_RDAP); step(C_BST); step(C_NOP); step(C_NOP); step(C_WR);
      @(negedge clk); chk("R6 ap after stop", pv(), 3'b100);
      pad(8);
      step(C_RDAP); step(C_NOP); step(C_WR);
      @(negedge clk); chk("R6 ap no stop", pv(), 3'b100);
      step(C_NOP); @(negedge clk); chk("R8 ap sticky", sticky_err, 3'b100);

      // R7 read interrupted by read
      pad(8);
      step(C_RD); @(negedge clk); chk("R7 read quiet", pv(), 3'b000);
      step(C_RDAP); @(negedge clk); chk("R7 reread quiet", pv(), 3'b000);
      step(C_RD); @(negedge clk); chk("R7 third read quiet", pv(), 3'b000);
      pad(3); step(C_WR);
      @(negedge clk); chk("R7 window from latest read", pv(), 3'b001);
      pad(8);
      step(C_RD); step(C_BST); step(C_RD); pad(2); step(C_WR);
      @(negedge clk); chk("R7 new read drops stop mark", pv(), 3'b001);

      // CL2.5, BL8: CLR 3, window 7
      pad(4);
      do_reset(2'd2, 1'b1, 2'd2);
      pad(2);
      step(C_RD); step(C_BST); step(C_NOP); step(C_WR);
      @(negedge clk); chk("R5 gap 2 flagged (R1 latched CL)", pv(), 3'b010);
      pad(8);
      step(C_RD); step(C_BST); step(C_NOP); step(C_NOP); step(C_WR);
      @(negedge clk); chk("R5 gap 3 legal", pv(), 3'b000);
      pad(8);
      step(C_RD); pad(6); step(C_WR);
      @(negedge clk); chk("R3 BL8 last beat (R1 latched BL)", pv(), 3'b001);
      pad(8);
      step(C_RD); pad(7); step(C_WR);
      @(negedge clk); chk("R3 BL8 after window", pv(), 3'b000);
      pad(4);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule